// File: doc/BRIEF.md
# Stuck Clock Failure Detector

This block watches a slow, low-power oscillator output from a faster reference clock that never stops. The watched signal is brought into the reference domain through a short flop chain. Every change of its synchronised level restarts a timeout counter. If the signal sits at either level, high or low, for longer than the timeout, the block sets a failure flag. The flag stays set until software clears it.

The timeout is given in reference-clock cycles. Its default is worked out from the reference frequency in MHz and a time limit in microseconds, which is 100 µs by default. A single enable bit arms the detector. Software drops this bit while it reconfigures the oscillator, so that the settling period cannot raise a false alarm. The flag can drive an interrupt request, a wake request and a reset request, and each of the three has its own enable. The interrupt and wake requests are levels. The reset request is a one-cycle pulse.

Top module: `stuck_clk_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fail_flag, irq_req, wake_req and rst_req are all 0.
- R2: With det_en high, when watch_clk changes level and then holds it, fail_flag reads 1 exactly TIMEOUT_CYC+4 reference cycles after the change and still reads 0 one cycle earlier. The four extra cycles are two synchroniser stages, one edge register and one flag register.
- R3: With det_en high, while watch_clk changes level at intervals of at most TIMEOUT_CYC reference cycles, fail_flag stays 0.
- R4: Once set, fail_flag stays 1 even after watch_clk resumes toggling, until a clear.
- R5: fail_clr sampled high at a clock edge makes fail_flag 0 after that edge, taking priority over a new detection. If the watched level is still stuck and det_en is high, the flag reads 1 again one cycle later.
- R6: irq_req equals fail_flag AND irq_en, and wake_req equals fail_flag AND wake_en.
- R7: rst_req is a one-cycle pulse in the first cycle that fail_flag reads 1, issued only if rst_en was high in the cycle before. No other cycle has it high.
- R8: While det_en is low, the timeout counter is held at zero and fail_flag cannot become 1. After det_en rises with watch_clk held steady, fail_flag reads 1 exactly TIMEOUT_CYC+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_ref_n | input | 1 | Asynchronous active-low reset, released synchronous to clk_ref |
| det_en | input | 1 | Arms the detector; low holds the counter at zero |
| watch_clk | input | 1 | Raw watched oscillator output, asynchronous |
| fail_clr | input | 1 | One-cycle strobe that clears the failure flag |
| irq_en | input | 1 | Lets the flag drive irq_req |
| wake_en | input | 1 | Lets the flag drive wake_req |
| rst_en | input | 1 | Lets the flag's rising edge pulse rst_req |
| fail_flag | output | 1 | Sticky failure flag |
| irq_req | output | 1 | Interrupt request level |
| wake_req | output | 1 | Wake request level |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench measures the detection latency to the exact cycle, on both sides of the boundary. A design that counted one stage too many or too few in the synchroniser or the counter would raise the flag a cycle early or late. It toggles the watched clock just inside the limit, where a counter that failed to reload on an edge, or that reloaded on one polarity only, would report a failure that never happened. It also clears the flag while the clock is still stuck, where a set-over-clear priority would leave the flag stuck at 1. Finally it re-arms the detector after a long disabled hold, where a counter left free-running while disabled would fire at once instead of after a full timeout.

// File: rtl/stuck_clk_pkg.sv
package stuck_clk_pkg;

  // Reference cycles spanned by a time limit, given the reference rate in MHz.
  function automatic int unsigned limit_cycles(input int unsigned ref_mhz,
                                               input int unsigned limit_us);
    return ref_mhz * limit_us;
  endfunction

  // Per-request enables grouped as one bundle.
  typedef struct packed {
    logic irq;
    logic wake;
    logic rst;
  } req_en_t;

endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stg_d[i] = d;
    end else begin : g_next
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scm_edge.sv
module scm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic toggled
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // Either polarity of change counts as activity.
  assign toggled = lvl ^ prev_q;

endmodule

// File: rtl/scm_timer.sv
module scm_timer #(
  parameter int unsigned LIMIT = 12500,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart)    cnt_d = '0;
    else if (cnt_q != LIMIT_V) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign expired = (cnt_q == LIMIT_V);

endmodule

// File: rtl/stuck_clk_monitor.sv
module stuck_clk_monitor
  import stuck_clk_pkg::*;
#(
  parameter int unsigned REF_MHZ     = 125,
  parameter int unsigned LIMIT_US    = 100,
  parameter int unsigned TIMEOUT_CYC = limit_cycles(REF_MHZ, LIMIT_US),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_ref_n,
  input  logic det_en,
  input  logic watch_clk,
  input  logic fail_clr,
  input  logic irq_en,
  input  logic wake_en,
  input  logic rst_en,
  output logic fail_flag,
  output logic irq_req,
  output logic wake_req,
  output logic rst_req
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  req_en_t          req_en;
  logic             watch_sync;
  logic             watch_edge;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_expired;
  logic             fail_set;
  logic             flag_q;
  logic             flag_d;
  logic             rst_pulse_q;
  logic             rst_pulse_d;

  assign req_en = '{irq: irq_en, wake: wake_en, rst: rst_en};

  scm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk_ref),
    .rst_n (rst_ref_n),
    .d     (watch_clk),
    .q     (watch_sync)
  );

  scm_edge i_edge (
    .clk     (clk_ref),
    .rst_n   (rst_ref_n),
    .lvl     (watch_sync),
    .toggled (watch_edge)
  );

  scm_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk     (clk_ref),
    .rst_n   (rst_ref_n),
    .run     (det_en),
    .restart (watch_edge),
    .cnt     (tmr_cnt),
    .expired (tmr_expired)
  );

  // Next-state: clear wins over a fresh detection.
  always_comb begin
    fail_set    = det_en & tmr_expired;
    flag_d      = fail_clr ? 1'b0 : (flag_q | fail_set);
    rst_pulse_d = req_en.rst & flag_d & ~flag_q;
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      flag_q      <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      flag_q      <= flag_d;
      rst_pulse_q <= rst_pulse_d;
    end
  end

  assign fail_flag = flag_q;
  assign irq_req   = flag_q & req_en.irq;
  assign wake_req  = flag_q & req_en.wake;
  assign rst_req   = rst_pulse_q;

endmodule

// File: rtl/stuck_clk_monitor_chk.sv
module stuck_clk_monitor_chk #(
  parameter int unsigned TIMEOUT_CYC = 12500,
  parameter int unsigned CNT_W       = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             fail_clr,
  input logic             irq_en,
  input logic             fail_flag,
  input logic             irq_req,
  input logic             rst_req,
  input logic [CNT_W-1:0] tmr_cnt
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fail_flag && !fail_clr |=> fail_flag); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) fail_clr |=> !fail_flag); // R5
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !det_en && !fail_flag |=> !fail_flag); // R8
  AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !det_en |=> tmr_cnt == '0); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tmr_cnt <= CNT_W'(TIMEOUT_CYC)); // R2
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R7
  AST_RST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> fail_flag && !$past(fail_flag)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> fail_flag && irq_en); // R6

endmodule

bind stuck_clk_monitor stuck_clk_monitor_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .CNT_W       (CNT_W)
) i_chk (
  .clk       (clk_ref),
  .rst_n     (rst_ref_n),
  .det_en    (det_en),
  .fail_clr  (fail_clr),
  .irq_en    (irq_en),
  .fail_flag (fail_flag),
  .irq_req   (irq_req),
  .rst_req   (rst_req),
  .tmr_cnt   (tmr_cnt)
);

// File: tb/test_stuck_clk_monitor.sv
module test_stuck_clk_monitor;

  localparam int unsigned T = 16;

  logic clk_ref = 1'b0;
  logic rst_ref_n;
  logic det_en, watch_clk, fail_clr, irq_en, wake_en, rst_en;
  logic fail_flag, irq_req, wake_req, rst_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk_ref = ~clk_ref;

  stuck_clk_monitor #(.TIMEOUT_CYC(T)) i_stuck_clk_monitor (
    .clk_ref   (clk_ref),
    .rst_ref_n (rst_ref_n),
    .det_en    (det_en),
    .watch_clk (watch_clk),
    .fail_clr  (fail_clr),
    .irq_en    (irq_en),
    .wake_en   (wake_en),
    .rst_en    (rst_en),
    .fail_flag (fail_flag),
    .irq_req   (irq_req),
    .wake_req  (wake_req),
    .rst_req   (rst_req)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic t_reset();
    rst_ref_n = 1'b0; det_en = 1'b0; watch_clk = 1'b0; fail_clr = 1'b0;
    irq_en = 1'b1; wake_en = 1'b1; rst_en = 1'b1;
    step(3);
    chk("R1", "flag in reset", fail_flag, 1'b0);
    chk("R1", "irq in reset", irq_req, 1'b0);
    rst_ref_n = 1'b1;
    step(1);
    chk("R1", "flag after reset", fail_flag, 1'b0);
    chk("R1", "wake after reset", wake_req, 1'b0);
    chk("R1", "rst_req after reset", rst_req, 1'b0);
  endtask

  task automatic t_toggle_ok();
    logic seen = 1'b0;
    det_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      watch_clk = ~watch_clk;
      for (int c = 0; c < T - 2; c++) begin
        step(1);
        if (fail_flag) seen = 1'b1;
      end
    end
    chk("R3", "no flag while toggling near limit", seen, 1'b0);
  endtask

  task automatic t_stuck_high();
    watch_clk = 1'b1;
    step(T + 3);
    chk("R2", "flag one cycle before limit", fail_flag, 1'b0);
    step(1);
    chk("R2", "flag at limit", fail_flag, 1'b1);
    chk("R7", "rst_req on rise", rst_req, 1'b1);
    chk("R6", "irq_req with irq_en", irq_req, 1'b1);
    chk("R6", "wake_req with wake_en", wake_req, 1'b1);
    step(1);
    chk("R7", "rst_req drops after one cycle", rst_req, 1'b0);
  endtask

  task automatic t_sticky_clear();
    for (int k = 0; k < 10; k++) begin
      watch_clk = ~watch_clk;
      step(4);
    end
    chk("R4", "flag kept after clock resumes", fail_flag, 1'b1);
    fail_clr = 1'b1;
    step(1);
    fail_clr = 1'b0;
    chk("R5", "flag cleared by strobe", fail_flag, 1'b0);
    chk("R6", "irq_req follows cleared flag", irq_req, 1'b0);
  endtask

  task automatic t_stuck_low();
    int pulses = 0;
    irq_en = 1'b0; wake_en = 1'b1; rst_en = 1'b0;
    watch_clk = 1'b1;
    step(4);
    watch_clk = 1'b0;
    for (int c = 0; c < T + 8; c++) begin
      step(1);
      if (rst_req) pulses++;
    end
    chk("R2", "flag on stuck low", fail_flag, 1'b1);
    chk("R6", "irq_req masked", irq_req, 1'b0);
    chk("R6", "wake_req enabled", wake_req, 1'b1);
    chk("R7", "no rst_req when rst_en low", (pulses != 0), 1'b0);
  endtask

  task automatic t_clear_while_stuck();
    fail_clr = 1'b1;
    step(1);
    fail_clr = 1'b0;
    chk("R5", "clear wins while stuck", fail_flag, 1'b0);
    step(1);
    chk("R5", "re-detect one cycle after clear", fail_flag, 1'b1);
  endtask

  task automatic t_disabled();
    logic seen = 1'b0;
    rst_en = 1'b1;
    det_en = 1'b0;
    fail_clr = 1'b1;
    step(1);
    fail_clr = 1'b0;
    chk("R5", "clear while disabled", fail_flag, 1'b0);
    for (int c = 0; c < 3 * T; c++) begin
      step(1);
      if (fail_flag) seen = 1'b1;
    end
    chk("R8", "no flag while disabled and stuck", seen, 1'b0);
    det_en = 1'b1;
    step(T);
    chk("R8", "full timeout after enable (before)", fail_flag, 1'b0);
    step(1);
    chk("R8", "full timeout after enable (at)", fail_flag, 1'b1);
    chk("R7", "rst_req after re-enable", rst_req, 1'b1);
  endtask

  initial begin
    t_reset();
    t_toggle_ok();
    t_stuck_high();
    t_sticky_clear();
    t_stuck_low();
    t_clear_while_stuck();
    t_disabled();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule